// File: doc/BRIEF.md
# Flash Embedded-Algorithm Status Flag Generator

This block produces the status byte that a NOR-style flash returns while its internal program and erase engine runs. It follows the engine through seven conditions: idle, programming, the sector-erase collection window, erasing, reading while an erase is suspended, programming while an erase is suspended, and a locked timeout failure. Host software polls the byte to learn whether an operation is still running, whether it failed, whether more sectors may still be added to an erase, and which sectors are being erased.

Commands arrive as single-cycle strokes on a small command port. The array side reports two events: a pulse tick each time a program or erase pulse is applied, and a verify-pass signal when the target reads back correctly. A status read is a one-cycle strobe carrying a sector index. The status byte is valid during the strobe cycle; the two toggle flags then advance at the clock edge that ends the strobe, so two reads in a row give opposite toggle values.

The two toggle flags are deliberately different. The busy toggle (bit 6) moves on every read while an operation is active. The sector toggle (bit 2) moves only on reads that hit a sector in the erase set. Together they separate suspend-read from a running erase, and they show which sectors are being erased.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the engine is idle, the erase set is empty, both toggle flags are 0, and `status_o` reads 8'h00.
- R2: Bit 7 of `status_o` is the polling bit, bit 6 the busy toggle, bit 5 the timeout flag, bit 3 the erase-started flag and bit 2 the sector toggle. Bits 4, 1 and 0 always read 0.
- R3: A program command (`cmd_op`=1) accepted in idle starts programming. While programming, bit 7 reads the complement of `cmd_msb`. When `op_done` is seen with the target marked blank, the engine returns to idle and bit 7 reads the programmed `cmd_msb`.
- R4: A read strobe flips the busy toggle when the engine is programming, in the erase window, erasing, programming under suspend, or failed. The busy toggle holds in idle and in suspend-read.
- R5: Each `pulse_tick` during a program or an erase counts one pulse. The tick that brings the count to PULSE_LIMIT, with no `op_done` in the same cycle, moves the engine to the failed state. In that state bit 5 reads 1. Bit 7 reads the complement of the target bit after a failed program and 0 after a failed erase.
- R6: A program whose target was marked not blank (`cmd_blank`=0) ignores `op_done`. It stays busy and can end only through the pulse limit.
- R7: In the failed state every command except reset (`cmd_op`=5) is ignored. Reset returns the engine to idle with an empty erase set.
- R8: A sector erase (`cmd_op`=2) in idle opens the collection window with that sector in the erase set. While the window is open, bit 3 reads 0. Each further sector erase adds its sector and restarts the window. The window closes after EWIN_CYC cycles with no further sector erase.
- R9: Once the window has closed, bit 3 reads 1 while the erase set is non-empty, and further sector erase commands leave the erase set unchanged.
- R10: A read whose `rd_sector` lies in the erase set flips the sector toggle. A read of any other sector leaves it unchanged.
- R11: Suspend (`cmd_op`=3) during an erase enters suspend-read, and resume (`cmd_op`=4) returns to the erase. The erase pulse count is kept across the suspension.
- R12: A program issued in suspend-read programs under suspend. In that mode, bit 2 reads 1 for any sector outside the erase set. On completion the engine returns to suspend-read.
- R13: Bit 7 reads 0 during the window and the erase. When `op_done` arrives during the erase, the engine goes idle, the erase set is cleared, and bit 3 returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command stroke |
| cmd_op | input | 3 | 1 program, 2 sector erase, 3 suspend, 4 resume, 5 reset |
| cmd_sector | input | $clog2(N_SECT) | Sector of a sector erase command |
| cmd_msb | input | 1 | Bit 7 of the data being programmed |
| cmd_blank | input | 1 | Program target is erased (1) or not (0) |
| pulse_tick | input | 1 | One program/erase pulse applied |
| op_done | input | 1 | Array verify passed |
| rd_stb | input | 1 | Status read strobe |
| rd_sector | input | $clog2(N_SECT) | Sector addressed by the read |
| status_o | output | 8 | Status byte |

## Verification
The hardest state to reach is a program running under suspend, with an erase set built from more than one command, an erase pulse count partly used up before the suspension, and reads alternating between erased and untouched sectors. The directed sequence builds this step by step. It opens the window, adds a second sector just before the window would close, lets the window expire, spends part of the pulse budget, then suspends and programs. Later it resumes and spends the remaining pulses to show that the count was kept. A long stretch of random strokes then runs against the behavioural model, which is compared with the status byte every cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PROG    = 3'd1,
    OP_SERASE  = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4,
    OP_RESET   = 3'd5
  } fsg_op_e;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PROG      = 3'd1,
    ST_EWIN      = 3'd2,
    ST_ERASE     = 3'd3,
    ST_SUSP_RD   = 3'd4,
    ST_SUSP_PROG = 3'd5,
    ST_FAIL      = 3'd6
  } fsg_state_e;

  // States in which the busy toggle advances on a read.
  function automatic logic busy_toggles(fsg_state_e s);
    return (s == ST_PROG) || (s == ST_EWIN) || (s == ST_ERASE) ||
           (s == ST_SUSP_PROG) || (s == ST_FAIL);
  endfunction

  function automatic logic prog_running(fsg_state_e s);
    return (s == ST_PROG) || (s == ST_SUSP_PROG);
  endfunction

  // Polling bit: complement while a program runs, 0 through an erase,
  // true data otherwise.
  function automatic logic poll_value(fsg_state_e s, logic msb, logic failed_prog);
    case (s)
      ST_PROG, ST_SUSP_PROG: return ~msb;
      ST_EWIN, ST_ERASE:     return 1'b0;
      ST_FAIL:               return failed_prog ? ~msb : 1'b0;
      default:               return msb;
    endcase
  endfunction

endpackage

// File: rtl/fsg_engine.sv
module fsg_engine
  import fsg_pkg::*;
#(
  parameter int N_SECT      = 8,
  parameter int PULSE_LIMIT = 16,
  parameter int EWIN_CYC    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(N_SECT)-1:0] cmd_sector,
  input  logic                      cmd_msb,
  input  logic                      cmd_blank,
  input  logic                      pulse_tick,
  input  logic                      op_done,
  output fsg_state_e                st_o,
  output logic [N_SECT-1:0]         mask_o,
  output logic                      msb_o,
  output logic                      failed_prog_o
);

  localparam int PW = $clog2(PULSE_LIMIT + 1);
  localparam int TW = $clog2(EWIN_CYC + 1);

  fsg_state_e        st_q, st_d;
  logic [N_SECT-1:0] mask_q;
  logic [PW-1:0]     pcnt_q, ecnt_q;
  logic [TW-1:0]     tcnt_q;
  logic              msb_q, blank_q, failp_q;

  fsg_op_e op;
  assign op = fsg_op_e'(cmd_op);

  logic is_prog, is_serase, is_susp, is_resume, is_reset;
  assign is_prog   = cmd_valid && (op == OP_PROG);
  assign is_serase = cmd_valid && (op == OP_SERASE);
  assign is_susp   = cmd_valid && (op == OP_SUSPEND);
  assign is_resume = cmd_valid && (op == OP_RESUME);
  assign is_reset  = cmd_valid && (op == OP_RESET);

  logic [N_SECT-1:0] sect_bit;
  assign sect_bit = {{(N_SECT-1){1'b0}}, 1'b1} << cmd_sector;

  // Named internal events
  logic prog_start_evt, erase_start_evt, win_add_evt, win_close_evt;
  logic prog_done_evt, prog_limit_evt, erase_done_evt, erase_limit_evt;
  logic suspend_evt, resume_evt, fail_clear_evt;

  assign prog_start_evt  = is_prog && ((st_q == ST_IDLE) || (st_q == ST_SUSP_RD));
  assign erase_start_evt = is_serase && (st_q == ST_IDLE);
  assign win_add_evt     = is_serase && (st_q == ST_EWIN);
  assign win_close_evt   = (st_q == ST_EWIN) && !win_add_evt &&
                           (tcnt_q == TW'(EWIN_CYC - 1));
  assign prog_done_evt   = prog_running(st_q) && op_done && blank_q;
  assign prog_limit_evt  = prog_running(st_q) && !prog_done_evt && pulse_tick &&
                           (pcnt_q == PW'(PULSE_LIMIT - 1));
  assign erase_done_evt  = (st_q == ST_ERASE) && op_done;
  assign erase_limit_evt = (st_q == ST_ERASE) && !erase_done_evt && pulse_tick &&
                           (ecnt_q == PW'(PULSE_LIMIT - 1));
  assign suspend_evt     = (st_q == ST_ERASE) && !erase_done_evt && !erase_limit_evt &&
                           is_susp;
  assign resume_evt      = (st_q == ST_SUSP_RD) && is_resume;
  assign fail_clear_evt  = (st_q == ST_FAIL) && is_reset;

  always_comb begin
    st_d = st_q;
    if (fail_clear_evt)                        st_d = ST_IDLE;
    else if (prog_limit_evt || erase_limit_evt) st_d = ST_FAIL;
    else if (prog_done_evt)
      st_d = (st_q == ST_SUSP_PROG) ? ST_SUSP_RD : ST_IDLE;
    else if (erase_done_evt)                   st_d = ST_IDLE;
    else if (prog_start_evt)
      st_d = (st_q == ST_IDLE) ? ST_PROG : ST_SUSP_PROG;
    else if (erase_start_evt)                  st_d = ST_EWIN;
    else if (win_close_evt)                    st_d = ST_ERASE;
    else if (suspend_evt)                      st_d = ST_SUSP_RD;
    else if (resume_evt)                       st_d = ST_ERASE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mask_q  <= '0;
      pcnt_q  <= '0;
      ecnt_q  <= '0;
      tcnt_q  <= '0;
      msb_q   <= 1'b0;
      blank_q <= 1'b1;
      failp_q <= 1'b0;
    end else begin
      st_q <= st_d;

      if (prog_start_evt) begin
        msb_q   <= cmd_msb;
        blank_q <= cmd_blank;
        pcnt_q  <= '0;
      end else if (prog_running(st_q) && pulse_tick) begin
        pcnt_q <= pcnt_q + 1'b1;
      end

      if (erase_start_evt || win_add_evt) tcnt_q <= '0;
      else if (st_q == ST_EWIN)           tcnt_q <= tcnt_q + 1'b1;

      if (win_close_evt || fail_clear_evt)       ecnt_q <= '0;
      else if ((st_q == ST_ERASE) && pulse_tick) ecnt_q <= ecnt_q + 1'b1;

      if (erase_start_evt)                     mask_q <= sect_bit;
      else if (win_add_evt)                    mask_q <= mask_q | sect_bit;
      else if (erase_done_evt || fail_clear_evt) mask_q <= '0;

      if (prog_limit_evt)       failp_q <= 1'b1;
      else if (erase_limit_evt) failp_q <= 1'b0;
    end
  end

  assign st_o          = st_q;
  assign mask_o        = mask_q;
  assign msb_o         = msb_q;
  assign failed_prog_o = failp_q;

  // R7: the failed state is left only through a reset command
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL) && !is_reset |=> (st_q == ST_FAIL));

  // R5: reaching the pulse limit always lands in the failed state
  p_limit_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_limit_evt || erase_limit_evt) |=> (st_q == ST_FAIL));

  // R6: a program on a non-blank target moves only on a pulse tick
  p_nonblank_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_running(st_q) && !blank_q && !pulse_tick |=> $stable(st_q));

  // R9: once the erase runs, the erase set is frozen until completion
  p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERASE) && !erase_done_evt |=> $stable(mask_q));

  // R8: the window stays open while its counter has not expired
  p_window_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EWIN) && (tcnt_q != TW'(EWIN_CYC - 1)) |=> (st_q == ST_EWIN));

endmodule

// File: rtl/fsg_toggles.sv
module fsg_toggles
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  fsg_state_e st,
  input  logic       hit,
  output logic       busy_tog_o,
  output logic       sect_tog_o
);

  logic busy_q, sect_q;
  logic busy_adv, sect_adv;

  assign busy_adv = rd_stb && busy_toggles(st);
  assign sect_adv = rd_stb && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sect_q <= 1'b0;
    end else begin
      if (busy_adv) busy_q <= ~busy_q;
      if (sect_adv) sect_q <= ~sect_q;
    end
  end

  assign busy_tog_o = busy_q;
  assign sect_tog_o = sect_q;

  // R4: an idle read leaves the busy toggle alone
  p_busy_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && (st == ST_IDLE) |=> $stable(busy_q));

  // R11: suspend-read freezes the busy toggle
  p_busy_hold_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && (st == ST_SUSP_RD) |=> $stable(busy_q));

  // R10: a read inside the erase set flips the sector toggle
  p_sect_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && hit |=> (sect_q != $past(sect_q)));

  // R10: a read outside the erase set keeps it
  p_sect_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && hit) |=> $stable(sect_q));

endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
  import fsg_pkg::*;
(
  input  fsg_state_e st,
  input  logic       set_nonempty,
  input  logic       hit,
  input  logic       busy_tog,
  input  logic       sect_tog,
  input  logic       msb,
  input  logic       failed_prog,
  output logic [7:0] status_o
);

  always_comb begin
    status_o    = 8'h00;
    status_o[7] = poll_value(st, msb, failed_prog);
    status_o[6] = busy_tog;
    status_o[5] = (st == ST_FAIL);
    status_o[3] = set_nonempty && (st != ST_EWIN);
    status_o[2] = ((st == ST_SUSP_PROG) && !hit) ? 1'b1 : sect_tog;
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int N_SECT      = 8,
  parameter int PULSE_LIMIT = 16,
  parameter int EWIN_CYC    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(N_SECT)-1:0] cmd_sector,
  input  logic                      cmd_msb,
  input  logic                      cmd_blank,
  input  logic                      pulse_tick,
  input  logic                      op_done,
  input  logic                      rd_stb,
  input  logic [$clog2(N_SECT)-1:0] rd_sector,
  output logic [7:0]                status_o
);

  fsg_state_e        st;
  logic [N_SECT-1:0] mask;
  logic              msb, failed_prog, busy_tog, sect_tog, hit;

  assign hit = mask[rd_sector];

  fsg_engine #(
    .N_SECT(N_SECT), .PULSE_LIMIT(PULSE_LIMIT), .EWIN_CYC(EWIN_CYC)
  ) engine_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_msb(cmd_msb), .cmd_blank(cmd_blank),
    .pulse_tick(pulse_tick), .op_done(op_done), .st_o(st), .mask_o(mask),
    .msb_o(msb), .failed_prog_o(failed_prog)
  );

  fsg_toggles tog_i (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .st(st), .hit(hit),
    .busy_tog_o(busy_tog), .sect_tog_o(sect_tog)
  );

  fsg_status_mux mux_i (
    .st(st), .set_nonempty(|mask), .hit(hit), .busy_tog(busy_tog),
    .sect_tog(sect_tog), .msb(msb), .failed_prog(failed_prog),
    .status_o(status_o)
  );

  // R2: unused status bits never rise
  p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & 8'h13) == 8'h00);

  // R12: an untouched sector reads 1 on bit 2 while programming under suspend
  p_susp_prog_dq2_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP_PROG) && !mask[rd_sector] |-> status_o[2]);

endmodule

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb_top;
  import fsg_pkg::*;

  localparam int NS  = 8;
  localparam int LIM = 6;
  localparam int WIN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_msb = 0, cmd_blank = 1, pulse_tick = 0, op_done = 0, rd_stb = 0;
  logic [2:0] cmd_op = 0, cmd_sector = 0, rd_sector = 0;
  logic [7:0] status_o;

  always #10 clk = ~clk;

  flash_status_gen #(.N_SECT(NS), .PULSE_LIMIT(LIM), .EWIN_CYC(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_msb(cmd_msb), .cmd_blank(cmd_blank),
    .pulse_tick(pulse_tick), .op_done(op_done), .rd_stb(rd_stb),
    .rd_sector(rd_sector), .status_o(status_o)
  );

  int vectors = 0, miscompares = 0;
  logic [7:0] last_rd;

  // Behavioural model: 0 idle,1 prog,2 window,3 erase,4 susp-read,5 susp-prog,6 fail
  int m_st = 0, m_set = 0, pc = 0, ec = 0, tc = 0;
  bit m_msb = 0, m_blank = 1, m_failp = 0, t1 = 0, t2 = 0;

  function automatic logic [7:0] model_status();
    logic [7:0] s = 8'h00;
    bit hit = ((m_set >> rd_sector) & 1) != 0;
    if (m_st == 1 || m_st == 5) s[7] = !m_msb;
    else if (m_st == 2 || m_st == 3) s[7] = 1'b0;
    else if (m_st == 6) s[7] = m_failp ? !m_msb : 1'b0;
    else s[7] = m_msb;
    s[6] = t1;
    s[5] = (m_st == 6);
    s[3] = (m_set != 0) && (m_st != 2);
    s[2] = (m_st == 5 && !hit) ? 1'b1 : t2;
    return s;
  endfunction

  task automatic model_step();
    bit hit = ((m_set >> rd_sector) & 1) != 0;
    bit cv = cmd_valid;
    if (rd_stb) begin
      if (m_st inside {1, 2, 3, 5, 6}) t1 = !t1;
      if (hit) t2 = !t2;
    end
    case (m_st)
      0: if (cv && cmd_op == 1) begin m_st = 1; m_msb = cmd_msb; m_blank = cmd_blank; pc = 0; end
         else if (cv && cmd_op == 2) begin m_st = 2; m_set = 1 << cmd_sector; tc = 0; end
      1, 5: if (op_done && m_blank) m_st = (m_st == 5) ? 4 : 0;
            else if (pulse_tick) begin pc++; if (pc == LIM) begin m_st = 6; m_failp = 1; end end
      2: if (cv && cmd_op == 2) begin m_set |= 1 << cmd_sector; tc = 0; end
         else if (tc == WIN - 1) begin m_st = 3; ec = 0; end
         else tc++;
      3: if (op_done) begin m_st = 0; m_set = 0; end
         else begin
           if (pulse_tick) ec++;
           if (ec == LIM) begin m_st = 6; m_failp = 0; end
           else if (cv && cmd_op == 3) m_st = 4;
         end
      4: if (cv && cmd_op == 1) begin m_st = 5; m_msb = cmd_msb; m_blank = cmd_blank; pc = 0; end
         else if (cv && cmd_op == 4) m_st = 3;
      6: if (cv && cmd_op == 5) begin m_st = 0; m_set = 0; ec = 0; end
      default: ;
    endcase
  endtask

  function automatic string bit_tag(logic [7:0] d);
    if (d[7]) return "R3/R13 polling";
    if (d[6]) return "R4 busy toggle";
    if (d[5]) return "R5 timeout";
    if (d[3]) return "R8/R9 erase-started";
    if (d[2]) return "R10/R12 sector toggle";
    return "R2 spare bits";
  endfunction

  task automatic cyc();
    logic [7:0] e;
    #1;
    e = model_status();
    last_rd = status_o;
    vectors++;
    if (status_o !== e) begin
      miscompares++;
      $display("FAIL %s: status=%02h expected=%02h at %0t", bit_tag(status_o ^ e), status_o, e, $time);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmd_valid = 0; pulse_tick = 0; op_done = 0; rd_stb = 0;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cmd(fsg_op_e o, int sec, bit msb, bit blank);
    cmd_valid = 1; cmd_op = o; cmd_sector = sec[2:0]; cmd_msb = msb; cmd_blank = blank;
    cyc();
  endtask

  task automatic rd(int sec);
    rd_stb = 1; rd_sector = sec[2:0];
    cyc();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin pulse_tick = 1; cyc(); end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  logic a, b;

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status", status_o == 8'h00, 1'b1);
    rst_n = 1;
    @(negedge clk);

    // R3/R4: blank program with msb=1
    cmd(OP_PROG, 0, 1, 1);
    rd(0); a = last_rd[6];
    chk("R3 polling complement", last_rd[7], 1'b0);
    rd(0); b = last_rd[6];
    chk("R4 busy toggle flips while programming", a != b, 1'b1);
    ticks(2);
    op_done = 1; cyc();
    rd(3); a = last_rd[6];
    chk("R3 true data after completion", last_rd[7], 1'b1);
    rd(3); b = last_rd[6];
    chk("R4 busy toggle holds in idle", a == b, 1'b1);
    chk("R2 spare bits zero", (last_rd & 8'h13) == 0, 1'b1);

    // R5/R7: program hits the pulse limit
    cmd(OP_PROG, 0, 0, 1);
    ticks(LIM);
    rd(0);
    chk("R5 timeout flag", last_rd[5], 1'b1);
    chk("R5 polling after failed program", last_rd[7], 1'b1);
    cmd(OP_PROG, 0, 1, 1); cmd(OP_SERASE, 1, 0, 1); cmd(OP_RESUME, 0, 0, 1);
    rd(1);
    chk("R7 other commands ignored in fail", last_rd[5], 1'b1);
    cmd(OP_RESET, 0, 0, 1);
    rd(1);
    chk("R7 reset leaves fail", last_rd[5], 1'b0);

    // R6: non-blank program ignores verify pass
    cmd(OP_PROG, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin op_done = 1; cyc(); end
    rd(0);
    chk("R6 still busy despite op_done", last_rd[7], 1'b0);
    ticks(LIM);
    rd(0);
    chk("R6 non-blank ends in timeout", last_rd[5], 1'b1);
    cmd(OP_RESET, 0, 0, 1);

    // R8: window, additions restart it
    cmd(OP_SERASE, 2, 0, 1);
    rd(2); a = last_rd[2];
    chk("R8 window flag low", last_rd[3], 1'b0);
    chk("R13 polling 0 in window", last_rd[7], 1'b0);
    idle(4);
    cmd(OP_SERASE, 5, 0, 1);
    idle(WIN - 3);
    rd(5);
    chk("R8 window restarted by addition", last_rd[3], 1'b0);
    idle(WIN);
    // R9/R10
    rd(2); a = last_rd[2];
    chk("R9 erase-started flag", last_rd[3], 1'b1);
    rd(2); b = last_rd[2];
    chk("R10 sector toggle flips on erasing sector", a != b, 1'b1);
    rd(1); a = last_rd[2];
    rd(1); b = last_rd[2];
    chk("R10 sector toggle holds on other sector", a == b, 1'b1);
    cmd(OP_SERASE, 6, 0, 1);
    rd(6); a = last_rd[2];
    rd(6); b = last_rd[2];
    chk("R9 late sector erase not added", a == b, 1'b1);

    // R11/R12: suspend, program under suspend, resume
    ticks(LIM - 2);
    cmd(OP_SUSPEND, 0, 0, 1);
    rd(5); a = last_rd[6];
    rd(5); b = last_rd[6];
    chk("R11 busy toggle steady in suspend-read", a == b, 1'b1);
    rd(5); a = last_rd[2];
    rd(5); b = last_rd[2];
    chk("R11 sector toggle moves in suspend-read", a != b, 1'b1);
    cmd(OP_PROG, 0, 0, 1);
    rd(0);
    chk("R12 untouched sector reads 1", last_rd[2], 1'b1);
    rd(0);
    chk("R12 untouched sector reads 1 again", last_rd[2], 1'b1);
    op_done = 1; cyc();
    cmd(OP_RESUME, 0, 0, 1);
    ticks(1);
    rd(2);
    chk("R11 count kept, no early timeout", last_rd[5], 1'b0);
    op_done = 1; cyc();
    rd(2);
    chk("R13 erase-started cleared after completion", last_rd[3], 1'b0);
    chk("R13 true data after erase", last_rd[7], 1'b0);

    // R11/R5: count survives suspension and reaches the limit
    cmd(OP_SERASE, 4, 0, 1);
    idle(WIN + 1);
    ticks(LIM - 1);
    cmd(OP_SUSPEND, 0, 0, 1);
    cmd(OP_RESUME, 0, 0, 1);
    ticks(1);
    rd(4);
    chk("R11 kept count reaches limit", last_rd[5], 1'b1);
    chk("R5 polling 0 after failed erase", last_rd[7], 1'b0);
    chk("R9 erase-started stays in fail", last_rd[3], 1'b1);
    cmd(OP_RESET, 0, 0, 1);

    // Random stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      cmd_valid  = ($urandom_range(0, 9) < 3);
      cmd_op     = 3'($urandom_range(1, 5));
      cmd_sector = 3'($urandom_range(0, NS - 1));
      cmd_msb    = 1'($urandom_range(0, 1));
      cmd_blank  = ($urandom_range(0, 9) < 8);
      pulse_tick = ($urandom_range(0, 9) < 4);
      op_done    = ($urandom_range(0, 9) < 1);
      rd_stb     = 1'($urandom_range(0, 1));
      rd_sector  = 3'($urandom_range(0, NS - 1));
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule